// File: doc/BRIEF.md
# Prioritised Wake-Up Event Controller

This block gathers the wake-up causes of a low-power transmitter: the power-on reset, four push-buttons, a low-supply detector and a wake-up timer. It latches each cause in its own pending flag. It hands the flags one at a time to a single service slot and signals the serviced event to a host on an active-low interrupt line. The host acknowledges the serviced event with a serial status read. The status bits of that read come out on the interrupt line itself, one bit per serial-clock position. After the acknowledge, the next pending event moves into the slot, chosen by fixed priority.

The block also drives an oscillator-request output. This output stays high while any event is pending or being serviced, which keeps the reference clock running until the host has drained every event. The analog detectors, the button debouncing and the serial command decoding are outside the block. The block sees a read-in-progress level, a bit-position index and an acknowledge strobe.

Top module: `wk_event_ctrl`

## Requirements
- R1: After the synchronous reset is released, the power-on event (status position 0) is pending, and it is the first event placed in service, at the first clock edge with reset high.
- R2: A one-cycle pulse on any event input sets that event's pending flag at the next clock edge.
- R3: At most one event is in service. Events that arrive while one is in service stay pending, and the in-service event does not change without an acknowledge.
- R4: When the service slot is empty or is being acknowledged, and flags are pending, the pending event with the lowest status position is moved into service at that clock edge and its pending flag clears. The positions are 0 power-on, 1 to 4 buttons one to four, 5 low supply, 6 timer.
- R5: An event that recurs while its flag is already pending is merged into that flag. It is serviced once.
- R6: An acknowledge strobe when no event is in service has no effect.
- R7: When no status read is in progress, irq_n_o is low exactly while an event is in service.
- R8: During a status read (sr_busy_i high), irq_n_o carries a registered status bit. The bit is sampled at the clock edge after the position is presented. It is 1 when the event at that position is pending or in service.
- R9: Status positions 7 to 15 read as 0.
- R10: osc_req_o is high exactly while any flag is pending or an event is in service.
- R11: An event arriving in the same cycle as an acknowledge is not chosen at that edge. It is latched pending and is served on a later acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_evt_i | input | 4 | Debounced push-button event pulses, bit k = button k+1 |
| lowbat_evt_i | input | 1 | Low-supply detect event pulse |
| timer_evt_i | input | 1 | Wake-up timer expiry pulse |
| sr_busy_i | input | 1 | Status read in progress; irq line carries status bits |
| sr_pos_i | input | 4 | Serial-clock position of the status bit to present |
| sr_ack_i | input | 1 | One-cycle strobe closing a status read (acknowledge) |
| irq_n_o | output | 1 | Active-low interrupt, or status bit during a read |
| osc_req_o | output | 1 | Oscillator request while work remains |

## Verification
The hardest situation to reach is a backlog: several flags pending at once, an acknowledge landing in the same cycle as a fresh event, and a recurrence of an already pending cause. Only that mix exposes priority order, merging and the rule that same-cycle arrivals wait. Directed sequences load every source while power-on is still in service, then drain the queue one acknowledge at a time. A long seeded random phase fires sparse events, acknowledges and status reads at arbitrary positions, including positions past the last event. A bench reference model predicts every output cycle by cycle.

// File: rtl/wk_event_pkg.sv
// Shared constants for the wake-up event controller.
// Event positions double as priority (0 highest) and status-bit order.
package wk_event_pkg;
    localparam int N_BTN   = 4;
    localparam int N_EVT   = N_BTN + 3;
    localparam int EVT_W   = $clog2(N_EVT);
    localparam int POS_W   = 4;
    localparam int POS_N   = 1 << POS_W;
    localparam int POR_POS = 0;
    localparam int LBD_POS = N_BTN + 1;
    localparam int TMR_POS = N_BTN + 2;

    typedef logic [N_EVT-1:0] evt_vec_t;
    typedef logic [EVT_W-1:0] evt_idx_t;
endpackage

// File: rtl/wk_flag_bank.sv
// Pending-flag register bank.
// Holds one flag per event source. Set requests merge into an already
// set flag. A clear request removes a flag that moved into service.
// Set wins over clear in the same cycle, so an arrival is never lost.
// Assumes the clear vector is one-hot or zero.
module wk_flag_bank
    import wk_event_pkg::*;
#(
    parameter int        NUM      = N_EVT,
    parameter logic [NUM-1:0] RST_VAL = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] pend_o
);
    logic [NUM-1:0] pend_q;

    // Flag update: clear selected flag, then merge new arrivals.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= RST_VAL;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    // R3
    flag_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

    // R2
    flag_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(set_i) & ~pend_q) == '0) || !$past(rst_n)));
endmodule

// File: rtl/wk_prio_pick.sv
// Fixed-priority selector.
// Grants the lowest-numbered requesting position and reports its index.
// Assumes position 0 is the highest priority.
module wk_prio_pick
    import wk_event_pkg::*;
#(
    parameter int NUM = N_EVT,
    parameter int IW  = EVT_W
) (
    input  logic [NUM-1:0] req_i,
    output logic [NUM-1:0] gnt_o,
    output logic [IW-1:0]  idx_o,
    output logic           any_o
);
    logic [NUM:0] higher;

    assign higher[0] = 1'b0;

    // Chain of "a higher position already requests" terms.
    for (genvar g = 0; g < NUM; g++) begin : g_chain
        assign higher[g+1] = higher[g] | req_i[g];
        assign gnt_o[g]    = req_i[g] & ~higher[g];
    end

    assign any_o = higher[NUM];

    // Encode the one-hot grant into an index.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM; k++) begin
            if (gnt_o[k]) idx_o = IW'(k);
        end
    end
endmodule

// File: rtl/wk_status_shift.sv
// Status bit presenter for the serial status read.
// Registers the status bit for the requested clock position. This models
// the bit being launched on the serial-clock falling edge ahead of the
// host's sampling edge. Positions past the last event read as zero.
module wk_status_shift
    import wk_event_pkg::*;
#(
    parameter int NUM = N_EVT,
    parameter int PW  = POS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] stat_i,
    input  logic [PW-1:0]  pos_i,
    output logic           bit_o
);
    localparam int SPAN = 1 << PW;

    logic [SPAN-1:0] stat_ext;
    logic            bit_q;

    // Widen the status word so every position index is in range.
    always_comb begin
        stat_ext           = '0;
        stat_ext[NUM-1:0]  = stat_i;
    end

    // Launch the bit for the requested position.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= stat_ext[pos_i];
    end

    assign bit_o = bit_q;

    // R9
    far_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'($past(pos_i)) >= NUM) && $past(rst_n)) |-> !bit_q);
endmodule

// File: rtl/wk_event_ctrl.sv
// Prioritised wake-up event controller (top).
// Latches seven wake-up causes as pending flags. The power-on flag is set
// by reset. Exactly one event is serviced at a time; an acknowledge
// retires it and the highest-priority pending flag replaces it at the
// same edge. The interrupt line is low while an event is in service,
// and during a status read it carries the registered status bit.
// Assumes event inputs are single-cycle, synchronous, debounced pulses.
module wk_event_ctrl
    import wk_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BTN-1:0] btn_evt_i,
    input  logic             lowbat_evt_i,
    input  logic             timer_evt_i,
    input  logic             sr_busy_i,
    input  logic [POS_W-1:0] sr_pos_i,
    input  logic             sr_ack_i,
    output logic             irq_n_o,
    output logic             osc_req_o
);
    localparam evt_vec_t POR_MASK = evt_vec_t'(1) << POR_POS;

    evt_vec_t arrive;
    evt_vec_t pend;
    evt_vec_t clr;
    evt_vec_t gnt;
    evt_idx_t pick_idx;
    logic     pick_any;
    logic     svc_valid_q;
    evt_idx_t svc_idx_q;
    logic     slot_free;
    logic     take;
    evt_vec_t svc_onehot;
    evt_vec_t stat_word;
    logic     stat_bit;

    // Gather event inputs into status-position order.
    always_comb begin
        arrive                   = '0;
        arrive[N_BTN:1]          = btn_evt_i;
        arrive[LBD_POS]          = lowbat_evt_i;
        arrive[TMR_POS]          = timer_evt_i;
    end

    wk_flag_bank #(.NUM(N_EVT), .RST_VAL(POR_MASK)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (arrive),
        .clr_i  (clr),
        .pend_o (pend)
    );

    wk_prio_pick #(.NUM(N_EVT), .IW(EVT_W)) u_pick (
        .req_i (pend),
        .gnt_o (gnt),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    assign slot_free = !svc_valid_q || sr_ack_i;
    assign take      = slot_free && pick_any;
    assign clr       = take ? gnt : '0;

    // Service slot: load the picked event or retire on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_valid_q <= 1'b0;
            svc_idx_q   <= '0;
        end else if (take) begin
            svc_valid_q <= 1'b1;
            svc_idx_q   <= pick_idx;
        end else if (sr_ack_i) begin
            svc_valid_q <= 1'b0;
        end
    end

    // Status word: every latched cause, pending or in service.
    always_comb begin
        svc_onehot = '0;
        if (svc_valid_q) svc_onehot[svc_idx_q] = 1'b1;
        stat_word = pend | svc_onehot;
    end

    wk_status_shift #(.NUM(N_EVT), .PW(POS_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_word),
        .pos_i  (sr_pos_i),
        .bit_o  (stat_bit)
    );

    assign irq_n_o   = sr_busy_i ? !stat_bit : !svc_valid_q;
    assign osc_req_o = svc_valid_q || (pend != '0);

    // R3
    svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(svc_valid_q) && !$past(sr_ack_i) && $past(rst_n))
            |-> (svc_valid_q && svc_idx_q == $past(svc_idx_q)));

    // R4
    no_idle_backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_valid_q && pend != '0) |=> svc_valid_q);

    // R6
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_valid_q && pend == '0 && sr_ack_i && arrive == '0) |=> (!svc_valid_q && pend == '0));

    // R10
    osc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_req_o && !sr_busy_i) |-> irq_n_o);
endmodule

// File: tb/wk_event_ctrl_bench.sv
module wk_event_ctrl_bench;
    localparam int NE = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn_evt_i = '0;
    logic       lowbat_evt_i = 1'b0;
    logic       timer_evt_i = 1'b0;
    logic       sr_busy_i = 1'b0;
    logic [3:0] sr_pos_i = '0;
    logic       sr_ack_i = 1'b0;
    logic       irq_n_o;
    logic       osc_req_o;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [NE-1:0] m_pend;
    logic          m_av;
    int            m_ai;
    logic          m_bit;

    always #2.5 clk = ~clk;

    wk_event_ctrl u_wk_event_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_evt_i(btn_evt_i),
        .lowbat_evt_i(lowbat_evt_i), .timer_evt_i(timer_evt_i),
        .sr_busy_i(sr_busy_i), .sr_pos_i(sr_pos_i), .sr_ack_i(sr_ack_i),
        .irq_n_o(irq_n_o), .osc_req_o(osc_req_o)
    );

    function automatic logic [NE-1:0] ev_vec();
        return {timer_evt_i, lowbat_evt_i, btn_evt_i, 1'b0};
    endfunction

    function automatic logic exp_irq_n();
        return sr_busy_i ? !m_bit : !m_av;
    endfunction

    function automatic logic exp_osc();
        return m_av || (m_pend != '0);
    endfunction

    // Advance the reference model across one edge (inputs seen before edge).
    task automatic model_edge();
        logic [NE-1:0] st;
        logic [NE-1:0] np;
        st = m_pend;
        if (m_av) st[m_ai] = 1'b1;
        if (!rst_n) begin
            m_pend = 7'b0000001; m_av = 1'b0; m_ai = 0; m_bit = 1'b0;
        end else begin
            m_bit = (sr_pos_i < NE) ? st[sr_pos_i] : 1'b0;
            np = m_pend;
            if ((!m_av || sr_ack_i) && m_pend != '0) begin
                for (int i = NE - 1; i >= 0; i--) if (m_pend[i]) m_ai = i;
                m_av = 1'b1;
                np[m_ai] = 1'b0;
            end else if (sr_ack_i) begin
                m_av = 1'b0;
            end
            m_pend = np | ev_vec();
        end
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: edge, model update, compare outputs, clear strobes.
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        #1;
        chk(irq_n_o, exp_irq_n(), req);
        chk(osc_req_o, exp_osc(), req);
        btn_evt_i = '0; lowbat_evt_i = 1'b0; timer_evt_i = 1'b0; sr_ack_i = 1'b0;
    endtask

    // Read one status position; returns bit as seen on the irq line.
    task automatic read_pos(input int pos, input logic exp, input string req);
        sr_busy_i = 1'b1; sr_pos_i = 4'(pos);
        step(req);
        chk(!irq_n_o, exp, req);
        sr_busy_i = 1'b0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_pend = '0; m_av = 1'b0; m_ai = 0; m_bit = 1'b0;
        repeat (3) step("R1 reset");
        chk(irq_n_o, 1'b1, "R1 idle irq in reset");
        chk(osc_req_o, 1'b1, "R1 POR pending in reset");
        rst_n = 1'b1;
        step("R1 POR serviced");
        chk(irq_n_o, 1'b0, "R1 POR interrupt");
        read_pos(0, 1'b1, "R8 POR status bit");
        read_pos(3, 1'b0, "R8 PB3 clear");
        // Backlog while POR in service: R3 R5
        btn_evt_i = 4'b1010; timer_evt_i = 1'b1; lowbat_evt_i = 1'b1;
        step("R2 events latch");
        btn_evt_i = 4'b1000;
        step("R5 merge PB4");
        read_pos(2, 1'b1, "R2 PB2 pending");
        read_pos(4, 1'b1, "R2 PB4 pending");
        read_pos(6, 1'b1, "R2 timer pending");
        read_pos(9, 1'b0, "R9 far position");
        read_pos(15, 1'b0, "R9 last position");
        read_pos(1, 1'b0, "R3 PB1 not set");
        // Drain in priority order: POR -> PB2 -> PB4 -> LBD -> WKT
        sr_ack_i = 1'b1; step("R4 ack POR");
        read_pos(0, 1'b0, "R4 POR retired");
        read_pos(2, 1'b1, "R4 PB2 in service");
        sr_ack_i = 1'b1; btn_evt_i = 4'b0001; step("R11 ack with PB1 arrival");
        read_pos(4, 1'b1, "R11 PB4 chosen not PB1");
        read_pos(1, 1'b1, "R11 PB1 latched");
        sr_ack_i = 1'b1; step("R4 ack PB4");
        sr_ack_i = 1'b1; step("R4 ack PB1");
        read_pos(5, 1'b1, "R4 LBD next");
        sr_ack_i = 1'b1; step("R4 ack LBD");
        sr_ack_i = 1'b1; step("R5 ack WKT, queue empty");
        chk(irq_n_o, 1'b1, "R7 idle irq high");
        chk(osc_req_o, 1'b0, "R10 osc drops");
        sr_ack_i = 1'b1; step("R6 stray ack");
        chk(osc_req_o, 1'b0, "R6 nothing changed");
        read_pos(0, 1'b0, "R6 no flag set");
        // Random phase: R2 R3 R4 R7 R8 R9 R10
        for (int n = 0; n < 4000; n++) begin
            btn_evt_i    = 4'(($urandom % 10 == 0) ? (1 << ($urandom % 4)) : 0);
            lowbat_evt_i = ($urandom % 15 == 0);
            timer_evt_i  = ($urandom % 12 == 0);
            sr_ack_i     = ($urandom % 5 == 0);
            sr_busy_i    = ($urandom % 3 == 0);
            sr_pos_i     = 4'($urandom % 16);
            step("R7 R8 R10 random");
        end
        sr_busy_i = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule